// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Lock Reservation

This block picks, on every clock, which of several bus masters owns a shared bus. Each master sits at a fixed position in the request vector, and that position is both its identity and its rank. Position 0 is the most important master. Because positions are distinct, no two masters can ever share a rank. The arbiter samples a request bit and a lock bit per master on each rising edge. The decision is registered. It is presented as a one-hot grant vector, a valid flag and the binary index of the owner.

A master that gets the bus while its lock bit is high reserves the bus for itself in the next cycle. If it requests again in that cycle, it keeps the bus even when more important masters are also asking. A chain of locked requests therefore forms a transfer that cannot be broken up. If the reserving master does not request in the cycle right after, the reservation lapses and normal ranking resumes.

An unlocked owner that is still requesting can lose the bus to a more important master. This is a normal event, not a fault. The arbiter flags it with a one-cycle preempt pulse. The displaced master gets the bus back once the more important requests go away.

Top module: `prio_lock_arbiter`

## Requirements
- R1: A synchronous reset, sampled on the rising edge, clears the grant, the valid flag, the index, the hold flag and the preempt pulse to zero.
- R2: When no master requests at an edge, the outputs after that edge show no grant (valid low, grant vector all zero).
- R3: Without a reservation in force, the requesting master with the lowest index wins. The result appears on the outputs after the edge that sampled the requests.
- R4: The grant vector is one-hot when valid is high, and its set bit is at position gnt_idx_o. It is all zero when valid is low.
- R5: If the winner's lock bit is high at the edge that grants it, bus_held_o is high after that edge. If that master requests at the next edge, it is granted again, regardless of more important requesters.
- R6: A reserving master that is re-granted with its lock bit high keeps the reservation for one more cycle. If it is re-granted with its lock bit low, bus_held_o falls and the following edge uses plain ranking.
- R7: If the reserving master does not request at the next edge, the reservation is dropped and the lowest-index requester wins.
- R8: Lock bits of masters that do not win at an edge have no effect on the grant or on bus_held_o.
- R9: preempt_o is high for exactly the cycle after an edge where the previous owner was still requesting but a lower-index master won.
- R10: preempt_o stays low when the previous owner stopped requesting, when the owner keeps the bus, and when a reservation holds the bus.
- R11: A preempted master is granted again as soon as no lower-index master requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_MASTERS | Request bit per master, index = rank (0 most important) |
| lock_i | input | N_MASTERS | Lock bit per master, honoured only for the winner |
| gnt_o | output | N_MASTERS | One-hot grant |
| gnt_valid_o | output | 1 | A master holds the bus this cycle |
| gnt_idx_o | output | IDX_W | Index of the owner |
| bus_held_o | output | 1 | The current grant carries a reservation for the next cycle |
| preempt_o | output | 1 | One-cycle pulse: the previous unlocked owner was displaced |

## Verification
The bench first walks through directed sequences. It starts with an idle vector, then a lone requester, then a more important master joining while the owner keeps requesting. This separates plain ranking from preemption and from the resume that follows. Locked sequences separate a single reservation, a chained reservation, a lock dropped mid-chain and a reservation left unused. Further vectors set lock bits only on losing masters, which shows that only the winner's lock counts. A long stretch of random request and lock vectors then mixes every transition against a bench model, and a reset is asserted while the bus is held.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Why the registered owner was chosen.
    typedef enum logic [1:0] {
        WHY_NONE = 2'd0,   // nobody requested
        WHY_RANK = 2'd1,   // plain lowest-index selection
        WHY_HOLD = 2'd2    // a reservation kept the previous owner
    } arb_why_e;

    // Per-decision flags that travel alongside the owner index.
    typedef struct packed {
        logic     valid;
        logic     held;
        logic     preempt;
        arb_why_e why;
    } arb_flags_t;

    localparam arb_flags_t ARB_FLAGS_RESET = '{valid: 1'b0, held: 1'b0,
                                               preempt: 1'b0, why: WHY_NONE};

    // Width of an index into n masters, never below one bit.
    function automatic int unsigned arb_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/arb_rank_pick.sv
module arb_rank_pick #(
    parameter int unsigned N_MASTERS = 4,
    localparam int unsigned IDX_W = arb_pkg::arb_idx_w(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] req_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     idx_o
);
    // Scan from the least important end so the lowest set index is left last.
    always_comb begin
        idx_o = '0;
        for (int i = N_MASTERS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/arb_hold_ctl.sv
module arb_hold_ctl
    import arb_pkg::*;
#(
    parameter int unsigned N_MASTERS = 4,
    localparam int unsigned IDX_W = arb_idx_w(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [N_MASTERS-1:0] lock_i,
    input  arb_flags_t           cur_flags_i,
    input  logic [IDX_W-1:0]     cur_idx_i,
    output arb_flags_t           nxt_flags_o,
    output logic [IDX_W-1:0]     nxt_idx_o
);
    logic             rank_any;
    logic [IDX_W-1:0] rank_idx;
    logic             owner_asks;
    logic             keep_owner;

    arb_rank_pick #(.N_MASTERS(N_MASTERS)) u_rank (
        .req_i (req_i),
        .any_o (rank_any),
        .idx_o (rank_idx)
    );

    assign owner_asks = cur_flags_i.valid && req_i[cur_idx_i];
    assign keep_owner = cur_flags_i.held && owner_asks;

    always_comb begin
        nxt_flags_o = ARB_FLAGS_RESET;
        nxt_idx_o   = '0;
        if (keep_owner) begin
            nxt_idx_o         = cur_idx_i;
            nxt_flags_o.valid = 1'b1;
            nxt_flags_o.why   = WHY_HOLD;
        end else if (rank_any) begin
            nxt_idx_o         = rank_idx;
            nxt_flags_o.valid = 1'b1;
            nxt_flags_o.why   = WHY_RANK;
            // The owner is still asking but a better-ranked master took over.
            nxt_flags_o.preempt = owner_asks && (rank_idx != cur_idx_i);
        end
        // Only the winner's lock bit can reserve the next cycle.
        nxt_flags_o.held = nxt_flags_o.valid && lock_i[nxt_idx_o];
    end

endmodule

// File: rtl/prio_lock_arbiter.sv
module prio_lock_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned N_MASTERS = 4,
    localparam int unsigned IDX_W = arb_idx_w(N_MASTERS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [N_MASTERS-1:0] lock_i,
    output logic [N_MASTERS-1:0] gnt_o,
    output logic                 gnt_valid_o,
    output logic [IDX_W-1:0]     gnt_idx_o,
    output logic                 bus_held_o,
    output logic                 preempt_o
);
    arb_flags_t       flags_q, flags_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    arb_hold_ctl #(.N_MASTERS(N_MASTERS)) u_ctl (
        .req_i       (req_i),
        .lock_i      (lock_i),
        .cur_flags_i (flags_q),
        .cur_idx_i   (idx_q),
        .nxt_flags_o (flags_d),
        .nxt_idx_o   (idx_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= ARB_FLAGS_RESET;
            idx_q   <= '0;
        end else begin
            flags_q <= flags_d;
            idx_q   <= idx_d;
        end
    end

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_gnt
        assign gnt_o[g] = flags_q.valid && (idx_q == IDX_W'(g));
    end

    assign gnt_valid_o = flags_q.valid;
    assign gnt_idx_o   = idx_q;
    assign bus_held_o  = flags_q.held;
    assign preempt_o   = flags_q.preempt;

    // R4
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o) && (gnt_valid_o == (gnt_o != '0)));

    // R2
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0) |=> !gnt_valid_o);

    // R3
    granted_requested_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o |-> (($past(req_i) & gnt_o) != '0));

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_held_o && gnt_valid_o && ((req_i & gnt_o) != '0))
            |=> (gnt_valid_o && gnt_idx_o == $past(gnt_idx_o) && !preempt_o));

    // R6
    hold_reason_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q.why == WHY_HOLD) |-> ($past(bus_held_o) && !preempt_o));

    // R9
    preempt_rank_chk: assert property (@(posedge clk) disable iff (rst)
        preempt_o |-> ($past(gnt_valid_o) && gnt_valid_o
                       && gnt_idx_o < $past(gnt_idx_o)));

endmodule

// File: tb/prio_lock_arbiter_tb.sv
`timescale 1ns/1ps
module prio_lock_arbiter_tb;
    localparam int N = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  lock = '0;
    logic [N-1:0]  gnt;
    logic          gnt_valid;
    logic [IW-1:0] gnt_idx;
    logic          held;
    logic          preempt;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // expected packed: {gnt[3:0], valid, idx[1:0], held, preempt}
    logic [8:0] exp_q[$];
    string      tag_q[$];

    // bench model of the ownership state
    bit            m_valid = 0;
    logic [IW-1:0] m_idx = '0;
    bit            m_held = 0;

    prio_lock_arbiter #(.N_MASTERS(N)) u_dut (
        .clk(clk), .rst(rst), .req_i(req), .lock_i(lock),
        .gnt_o(gnt), .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx),
        .bus_held_o(held), .preempt_o(preempt)
    );

    always #4 clk = ~clk;

    task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got gnt=%b v=%b idx=%0d held=%b pre=%b exp gnt=%b v=%b idx=%0d held=%b pre=%b",
                     tag, act[8:5], act[4], act[3:2], act[1], act[0],
                     exp[8:5], exp[4], exp[3:2], exp[1], exp[0]);
        end
    endtask

    // Driver: applies one request/lock vector and predicts the outcome.
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] l, input string tag);
        bit            asks, nv, np, nh;
        logic [IW-1:0] ni;
        @(negedge clk);
        req  = r;
        lock = l;
        asks = m_valid && r[m_idx];
        nv = 0; ni = '0; np = 0;
        if (m_held && asks) begin
            nv = 1; ni = m_idx;
        end else begin
            for (int i = N - 1; i >= 0; i--) if (r[i]) begin nv = 1; ni = IW'(i); end
            np = nv && asks && (ni != m_idx);
        end
        nh = nv && l[ni];
        m_valid = nv; m_idx = ni; m_held = nh;
        exp_q.push_back({(nv ? (4'b0001 << ni) : 4'b0000), nv, ni, nh, np});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each registered result just after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                check({gnt, gnt_valid, gnt_idx, held, preempt}, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running exp finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({gnt, gnt_valid, gnt_idx, held, preempt}, 9'd0, "R1 reset state");
        rst = 0;

        step(4'b0000, 4'b0000, "R2 idle");
        step(4'b1000, 4'b0000, "R3 lone master 3");
        step(4'b1100, 4'b0000, "R9 master 2 displaces 3");
        step(4'b1100, 4'b0000, "R3 owner 2 stays");
        step(4'b1000, 4'b0000, "R11 master 3 resumes, R10 no pulse");
        step(4'b0110, 4'b0000, "R3 lowest of 1,2 wins");
        // single reservation
        step(4'b0100, 4'b0100, "R5 locked grant to 2");
        step(4'b0101, 4'b0000, "R5 reservation beats master 0");
        step(4'b0101, 4'b0000, "R6 lock dropped, R9 master 0 displaces 2");
        // unused reservation
        step(4'b0010, 4'b0010, "R5 locked grant to 1");
        step(4'b0001, 4'b0000, "R7 reservation lapses, R10");
        // loser lock bits
        step(4'b1000, 4'b0111, "R8 losers' lock ignored");
        step(4'b1001, 4'b0110, "R8 master 0 wins unlocked, R9");
        step(4'b0011, 4'b0010, "R8 held stays low");
        // chained reservation
        step(4'b0100, 4'b0100, "R6 chain start");
        step(4'b0111, 4'b0100, "R6 chain continues");
        step(4'b0111, 4'b0100, "R6 chain continues again");
        step(4'b0011, 4'b0000, "R7 owner leaves, R10");
        step(4'b0000, 4'b0000, "R2 idle after chain");
        for (int k = 0; k < 400; k++) begin
            step(4'($urandom), ((k % 3) == 0) ? 4'b0000 : 4'($urandom), "R3 R5 R9 random mix");
        end
        // reset while the bus is reserved
        step(4'b0010, 4'b0010, "R5 before reset");
        @(negedge clk);
        rst = 1; req = 4'b1111; lock = 4'b1111;
        @(negedge clk);
        check({gnt, gnt_valid, gnt_idx, held, preempt}, 9'd0, "R1 reset while held");
        m_valid = 0; m_idx = '0; m_held = 0;
        rst = 0;
        step(4'b0100, 4'b0000, "R3 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule